// File: doc/BRIEF.md
# Page-Write Engine with Busy Status Readout

This block models the write engine of a byte-wide nonvolatile memory as seen from its parallel bus. A host loads bytes one at a time with a write strobe. The bytes go into a one-page staging buffer of 64 bytes. Every accepted load restarts a load-window timer. When the window passes with no further accepted load, the engine starts its internal program phase. That phase lasts a fixed number of clock cycles. During it, only the staged bytes are copied into a small behavioural array, through a write port that the top module also brings out. When the program phase ends, busy deasserts.

From the first accepted load until the program phase ends, a read does not return array data. It returns a status byte:
- Bit 7 is the complement of bit 7 of the most recently accepted byte.
- Bit 6 flips on every read. It starts at 0 in each busy period.
- Bit 5 tells whether the load window has expired.
- Bits 4 to 0 read as zero.

The host can therefore poll for completion in any of three ways. Both time values are parameters in clock cycles. Their defaults correspond to a 150 µs load window and a 5 ms program time at a 250 MHz clock.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, busy is 0 and rdData is 0x00.
- R2: Loads to the page of the first load of a busy period go into the staging buffer, and a later load to the same byte replaces the earlier one. On completion, only the offsets loaded in that period are written to the array, with the last value loaded to each. Every other byte keeps its old contents.
- R3: Each accepted load restarts the load window. The program phase begins LOAD_CYC cycles after the last accepted load. Busy falls exactly LOAD_CYC + WRITE_CYC clock edges after the edge that accepted the last load.
- R4: While busy, status bit 5 reads 0 during the load window and 1 during the program phase.
- R5: While busy, status bit 7 of a read at any address is the complement of bit 7 of the last accepted byte. After completion, a read of that byte returns its true value.
- R6: While busy, status bit 6 is 0 on the first read of the busy period and inverts on each following read.
- R7: While busy, status bits 4 to 0 read as 0.
- R8: During the load window, a load whose address lies in a different page from the first load is ignored. It neither enters the array nor restarts the window.
- R9: Write strobes during the program phase are ignored. They do not change the array, the polled bit 7 or the completion time.
- R10: When not busy, a read returns the array byte at rdAddr.
- R11: rdData updates on the clock edge that samples rdStb and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrStb | input | 1 | Byte-load strobe, one cycle per byte |
| wrAddr | input | ADDR_W | Byte address of the load |
| wrData | input | 8 | Byte to load |
| rdStb | input | 1 | Read strobe |
| rdAddr | input | ADDR_W | Read byte address |
| rdData | output | 8 | Registered read data or status byte |
| busy | output | 1 | High from the first accepted load until the program phase ends |
| arrWe | output | 1 | Array write enable during commit |
| arrAddr | output | ADDR_W | Array write address |
| arrWdata | output | 8 | Array write data |

## Verification
The bench measures the edge count from the last accepted load to the fall of busy. A load window that is not restarted, or that is restarted by off-page or late writes, shows up as a wrong count.

Several cases check the array contents after commit:
- A repeated load to one offset. Committing the first value would be caught.
- Bytes that were not loaded next to bytes that were. Committing the whole buffer would be caught.
- Ignored writes to a different page or during the program phase. Letting any of them through would be caught.

Each busy period is polled several times. Each field of the status byte is compared on its own. A toggle that does not restart at 0 for a new period, a bit 5 that flips at the wrong time, and a bit 7 taken from the wrong byte each give a field mismatch.

// File: rtl/eewr_pkg.sv
package eewr_pkg;

  // A page is 64 bytes; the offset field is the low address bits.
  localparam int PAGE_BYTES = 64;
  localparam int OFF_W      = $clog2(PAGE_BYTES);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } eng_state_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic             bufLoad;    // accept wrData into the staging buffer
    logic             firstLoad;  // first load of a busy period: latch page, clear valids
    logic             commitEn;   // commit slot active for commitOff
    logic [OFF_W-1:0] commitOff;  // offset being committed
    logic             busy;       // load window or program phase
    logic             timedOut;   // program phase (load window expired)
  } eng_strobe_t;

endpackage

// File: rtl/eewr_ctrl.sv
module eewr_ctrl
  import eewr_pkg::*;
#(
  parameter int LOAD_CYC  = 37500,    // load window in clock cycles
  parameter int WRITE_CYC = 1250000   // program phase in clock cycles, >= PAGE_BYTES
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrStb,
  input  logic        samePage,
  output eng_strobe_t strb
);

  localparam int LDW = $clog2(LOAD_CYC + 1);
  localparam int PGW = $clog2(WRITE_CYC + 1);
  localparam logic [LDW-1:0] LOAD_RELOAD = LDW'(LOAD_CYC - 1);
  localparam logic [PGW-1:0] PROG_LAST   = PGW'(WRITE_CYC - 1);
  localparam logic [PGW-1:0] COMMIT_END  = PGW'(PAGE_BYTES);

  eng_state_e     state;
  logic [LDW-1:0] loadCtr;
  logic [PGW-1:0] progCtr;
  logic           accept;

  always_comb begin
    accept = wrStb && ((state == ST_IDLE) || ((state == ST_LOAD) && samePage));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      loadCtr <= '0;
      progCtr <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_LOAD;
            loadCtr <= LOAD_RELOAD;
          end
        end
        ST_LOAD: begin
          if (accept) begin
            loadCtr <= LOAD_RELOAD;
          end else if (loadCtr == '0) begin
            state   <= ST_PROG;
            progCtr <= '0;
          end else begin
            loadCtr <= loadCtr - 1'b1;
          end
        end
        ST_PROG: begin
          if (progCtr == PROG_LAST) begin
            state <= ST_IDLE;
          end else begin
            progCtr <= progCtr + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.bufLoad   = accept;
    strb.firstLoad = accept && (state == ST_IDLE);
    strb.commitEn  = (state == ST_PROG) && (progCtr < COMMIT_END);
    strb.commitOff = progCtr[OFF_W-1:0];
    strb.busy      = (state != ST_IDLE);
    strb.timedOut  = (state == ST_PROG);
  end

  // R3: busy only ends out of the program phase.
  assert_busy_end_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strb.busy) |-> $past(strb.timedOut));

  // R3: the program phase is entered only from an open load window.
  assert_prog_entry_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.timedOut) |-> $past(strb.busy));

  // R9: no load is accepted during the program phase.
  assert_no_load_prog_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && strb.timedOut) |=> $stable(strb.timedOut) || !strb.busy);

endmodule

// File: rtl/eewr_datapath.sv
module eewr_datapath
  import eewr_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  eng_strobe_t       strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              rdStb,
  input  logic [7:0]        arrRdData,
  output logic              samePage,
  output logic              arrWe,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [7:0]        arrWdata,
  output logic [7:0]        rdData
);

  localparam int PAGE_W = ADDR_W - OFF_W;

  logic [PAGE_W-1:0]     pageBase;
  logic [PAGE_BYTES-1:0] bufValid;
  logic [7:0]            bufData [PAGE_BYTES];
  logic [7:0]            lastData;
  logic                  togState;
  logic [OFF_W-1:0]      wrOff;

  always_comb begin
    wrOff    = wrAddr[OFF_W-1:0];
    samePage = (wrAddr[ADDR_W-1:OFF_W] == pageBase);
  end

  // Page tag, valid map and last accepted byte.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageBase <= '0;
      bufValid <= '0;
      lastData <= '0;
    end else if (strb.bufLoad) begin
      lastData <= wrData;
      if (strb.firstLoad) begin
        pageBase <= wrAddr[ADDR_W-1:OFF_W];
        bufValid <= PAGE_BYTES'(1) << wrOff;
      end else begin
        bufValid[wrOff] <= 1'b1;
      end
    end
  end

  // Staging storage, no reset needed: guarded by bufValid.
  always_ff @(posedge clk) begin
    if (strb.bufLoad) begin
      bufData[wrOff] <= wrData;
    end
  end

  // Commit port.
  always_comb begin
    arrWe    = strb.commitEn && bufValid[strb.commitOff];
    arrAddr  = {pageBase, strb.commitOff};
    arrWdata = bufData[strb.commitOff];
  end

  // Read path: status byte while busy, array byte otherwise.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData   <= '0;
      togState <= 1'b0;
    end else begin
      if (rdStb) begin
        if (strb.busy) begin
          rdData <= {~lastData[7], togState, strb.timedOut, 5'b00000};
        end else begin
          rdData <= arrRdData;
        end
      end
      if (!strb.busy) begin
        togState <= 1'b0;
      end else if (rdStb) begin
        togState <= ~togState;
      end
    end
  end

  // R9: the polled byte and page stay fixed during the program phase.
  assert_hold_prog_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.timedOut |=> $stable(lastData) && $stable(pageBase));

  // R4: a read inside the load window shows bit 5 low.
  assert_window_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && strb.busy && !strb.timedOut) |=> !rdData[5]);

  // R6: back-to-back busy reads alternate bit 6.
  assert_toggle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && strb.busy && $past(rdStb && strb.busy)) |=> (rdData[6] != $past(rdData[6])));

  // R7: low status bits are zero on busy reads.
  assert_low_bits_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && strb.busy) |=> (rdData[4:0] == 5'b00000));

endmodule

// File: rtl/eewr_array.sv
module eewr_array #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wAddr,
  input  logic [7:0]        wData,
  input  logic [ADDR_W-1:0] rAddr,
  output logic [7:0]        rData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[wAddr] <= wData;
    end
  end

  assign rData = mem[rAddr];

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import eewr_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int LOAD_CYC  = 37500,
  parameter int WRITE_CYC = 1250000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              rdStb,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              busy,
  output logic              arrWe,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [7:0]        arrWdata
);

  eng_strobe_t strb;
  logic        samePage;
  logic [7:0]  arrRdData;

  eewr_ctrl #(
    .LOAD_CYC (LOAD_CYC),
    .WRITE_CYC(WRITE_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrStb   (wrStb),
    .samePage(samePage),
    .strb    (strb)
  );

  eewr_datapath #(
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .rdStb    (rdStb),
    .arrRdData(arrRdData),
    .samePage (samePage),
    .arrWe    (arrWe),
    .arrAddr  (arrAddr),
    .arrWdata (arrWdata),
    .rdData   (rdData)
  );

  eewr_array #(
    .ADDR_W(ADDR_W)
  ) u_arr (
    .clk  (clk),
    .we   (arrWe),
    .wAddr(arrAddr),
    .wData(arrWdata),
    .rAddr(rdAddr),
    .rData(arrRdData)
  );

  assign busy = strb.busy;

  // R2: array writes happen only in the program phase.
  assert_commit_in_prog_R2: assert property (@(posedge clk) disable iff (!rstN)
    arrWe |-> (busy && strb.timedOut));

endmodule

// File: tb/eeprom_page_writer_tb.sv
module eeprom_page_writer_tb;

  localparam int AW = 10;
  localparam int L  = 24;
  localparam int W  = 80;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrStb = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [7:0]    wrData = '0;
  logic          rdStb = 1'b0;
  logic [AW-1:0] rdAddr = '0;
  logic [7:0]    rdData;
  logic          busy;
  logic          arrWe;
  logic [AW-1:0] arrAddr;
  logic [7:0]    arrWdata;

  eeprom_page_writer #(.ADDR_W(AW), .LOAD_CYC(L), .WRITE_CYC(W)) u_dut (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrAddr(wrAddr), .wrData(wrData),
    .rdStb(rdStb), .rdAddr(rdAddr), .rdData(rdData), .busy(busy),
    .arrWe(arrWe), .arrAddr(arrAddr), .arrWdata(arrWdata));

  always #2 clk = ~clk;

  int   checks = 0;
  int   errors = 0;
  bit   finished = 0;
  logic [7:0] mdl [1 << AW];
  bit         known [1 << AW];
  logic [7:0] pend [1 << AW];
  bit         pendV [1 << AW];
  logic [7:0] lastLoaded = '0;
  bit         togExp = 0;

  function automatic logic [AW-1:0] mkAddr(input int page, input int off);
    return AW'(page * 64 + off);
  endfunction

  function automatic logic [7:0] statusExp(input bit timed);
    return {~lastLoaded[7], togExp, timed, 5'b00000};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Each task starts and ends at a falling edge and spans one rising edge.
  task automatic loadByte(input logic [AW-1:0] a, input logic [7:0] d);
    wrStb = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  task automatic acceptLoad(input logic [AW-1:0] a, input logic [7:0] d);
    pend[a] = d; pendV[a] = 1'b1; lastLoaded = d;
    loadByte(a, d);
  endtask

  task automatic readAt(input logic [AW-1:0] a, output logic [7:0] d);
    rdStb = 1'b1; rdAddr = a;
    @(negedge clk);
    rdStb = 1'b0;
    d = rdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busyRead(input logic [AW-1:0] a, input bit timed);
    logic [7:0] d, e;
    readAt(a, d);
    e = statusExp(timed);
    chk(d[5] == e[5], "R4", "status bit5", int'(d[5]), int'(e[5]));
    chk(d[7] == e[7], "R5", "polled bit7", int'(d[7]), int'(e[7]));
    chk(d[6] == e[6], "R6", "toggle bit6", int'(d[6]), int'(e[6]));
    chk(d[4:0] == 5'b0, "R7", "low status bits", int'(d[4:0]), 0);
    togExp = ~togExp;
  endtask

  task automatic finishTxn(output int n);
    n = 0;
    while (busy && n < L + W + 100) begin
      @(negedge clk);
      n++;
    end
    for (int i = 0; i < (1 << AW); i++) begin
      if (pendV[i]) begin
        mdl[i] = pend[i]; known[i] = 1'b1; pendV[i] = 1'b0;
      end
    end
    togExp = 0;
  endtask

  task automatic checkAddr(input logic [AW-1:0] a, input string tag);
    logic [7:0] d;
    readAt(a, d);
    chk(d == mdl[a], tag, "array readback", int'(d), int'(mdl[a]));
  endtask

  task automatic singleWrite(input logic [AW-1:0] a, input logic [7:0] d);
    int n;
    acceptLoad(a, d);
    finishTxn(n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    logic [7:0] d;
    void'($urandom(32'd4242));
    for (int i = 0; i < (1 << AW); i++) begin
      known[i] = 0; pendV[i] = 0; mdl[i] = '0; pend[i] = '0;
    end
    idle(3);
    rstN = 1'b1;
    idle(2);

    // R1 reset state
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(rdData == 8'h00, "R1", "rdData after reset", int'(rdData), 0);

    // R3 exact busy length for a single byte; R4/R5/R6 early poll
    acceptLoad(mkAddr(3, 5), 8'hA5);
    n = 1;
    busyRead(mkAddr(3, 5), 1'b0);
    begin
      int m;
      finishTxn(m);
      n += m;
    end
    chk(n == L + W, "R3", "busy length single byte", n, L + W);
    readAt(mkAddr(3, 5), d);
    chk(d == 8'hA5, "R5", "true byte after completion", int'(d), 8'hA5);
    chk(d == 8'hA5, "R10", "idle read returns array", int'(d), 8'hA5);
    idle(4);
    chk(rdData == 8'hA5, "R11", "rdData held between reads", int'(rdData), 8'hA5);

    // R3 window restart by a same-page load
    acceptLoad(mkAddr(2, 0), 8'h3C);
    idle(L - 3);
    acceptLoad(mkAddr(2, 1), 8'hC3);
    finishTxn(n);
    chk(n == L + W, "R3", "busy length after restart", n, L + W);
    checkAddr(mkAddr(2, 0), "R2");
    checkAddr(mkAddr(2, 1), "R2");

    // R2 overwrite and untouched neighbour
    singleWrite(mkAddr(4, 8), 8'h33);
    acceptLoad(mkAddr(4, 7), 8'h11);
    acceptLoad(mkAddr(4, 7), 8'h22);
    finishTxn(n);
    checkAddr(mkAddr(4, 7), "R2");
    chk(mdl[mkAddr(4, 7)] == 8'h22, "R2", "model overwrite", int'(mdl[mkAddr(4, 7)]), 8'h22);
    checkAddr(mkAddr(4, 8), "R2");

    // R8 off-page load ignored, window not restarted
    singleWrite(mkAddr(6, 1), 8'h66);
    acceptLoad(mkAddr(5, 1), 8'h44);
    loadByte(mkAddr(6, 1), 8'h55);
    begin
      int m;
      finishTxn(m);
      n = m + 1;
    end
    chk(n == L + W, "R8", "off-page load did not extend window", n, L + W);
    checkAddr(mkAddr(6, 1), "R8");
    checkAddr(mkAddr(5, 1), "R8");

    // R9 writes during program phase ignored
    singleWrite(mkAddr(7, 3), 8'h12);
    acceptLoad(mkAddr(7, 2), 8'h77);
    idle(L + 2);
    busyRead(mkAddr(9, 9), 1'b1);
    loadByte(mkAddr(7, 2), 8'h88);
    loadByte(mkAddr(7, 3), 8'h99);
    busyRead(mkAddr(7, 2), 1'b1);
    chk(busy == 1'b1, "R9", "still busy after late writes", int'(busy), 1);
    finishTxn(n);
    checkAddr(mkAddr(7, 2), "R9");
    checkAddr(mkAddr(7, 3), "R9");

    // Random transactions
    for (int t = 0; t < 30; t++) begin
      int page, cnt;
      page = int'($urandom_range(0, 15));
      cnt = int'($urandom_range(1, 6));
      for (int k = 0; k < cnt; k++) begin
        logic [AW-1:0] a;
        a = mkAddr(page, int'($urandom_range(0, 63)));
        acceptLoad(a, 8'($urandom));
        busyRead(mkAddr(int'($urandom_range(0, 15)), int'($urandom_range(0, 63))), 1'b0);
        if ($urandom_range(0, 2) == 0) begin
          loadByte(mkAddr(page ^ 1, int'($urandom_range(0, 63))), 8'($urandom));
        end
        idle(int'($urandom_range(0, L - 5)));
      end
      idle(L);
      busyRead(mkAddr(page, 0), 1'b1);
      loadByte(mkAddr(page, int'($urandom_range(0, 63))), 8'($urandom));
      busyRead(mkAddr(page, 1), 1'b1);
      finishTxn(n);
      chk(!busy, "R3", "random txn completed", int'(busy), 0);
      for (int o = 0; o < 64; o++) begin
        if (known[mkAddr(page, o)]) checkAddr(mkAddr(page, o), "R2");
        if (known[mkAddr(page ^ 1, o)] && o < 4) checkAddr(mkAddr(page ^ 1, o), "R8");
      end
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule